// File: doc/BRIEF.md
# Receive Packet Header Stripper

This block sits in a receive channel between the link receiver and the write buffer that feeds the DMA engine. It accepts packet bytes on a valid/ready stream. Each beat carries one byte, and the last beat of a packet is flagged as an end, optionally qualified as an error end. Per channel control inputs decide whether the leading address byte is removed, or both the address byte and the protocol-id byte that follows it. The first byte of every packet is checked against a node address: either the channel's own address or the shared one. The block also enforces a maximum delivered length.

Before it admits a packet, the block looks at whether a receive descriptor is ready. If none is ready, it either throws the whole packet away or holds the link stalled until one appears, depending on a no-spill control. The trimmed stream leaves on a second valid/ready interface. There is a one-cycle pulse for each truncated packet and another for each packet closed by an error end.

Each accepted input beat yields at most one output beat. This is why an empty or truncated packet is closed by a "marker" beat that carries no data.

Top module: `rx_hdr_strip`

## Requirements
- R1: With strip-address set and strip-pid clear, the first byte of each admitted packet is not delivered. All later bytes are delivered in order.
- R2: With strip-pid set, the first two bytes of each admitted packet are not delivered, whatever the strip-address setting is.
- R3: With both strip controls clear, every byte is delivered in order. The beat with the last byte has outEnd set and outNoData clear.
- R4: The first byte is compared with cfgOwnAddr when cfgUseOwnAddr is 1, and with cfgNodeAddr otherwise. On a mismatch, the whole packet is consumed with no output beat and no status pulse.
- R5: With cfgNoSpill at 0 and descAvail at 0 when a packet's first byte arrives, the whole packet is consumed with no output and no pulse.
- R6: With cfgNoSpill at 1 and descAvail at 0, inReady stays low at a packet start and no beat is consumed. Once descAvail rises, the packet is processed normally.
- R7: Delivered data bytes are counted after stripping. In a packet that would deliver more than cfgMaxLen bytes, only the first cfgMaxLen are delivered. They are followed by one marker beat (outNoData=1, outEnd=1, outErr=0). The rest of the input is consumed up to its end, and truncPulse fires once. A packet of exactly cfgMaxLen bytes is not truncated.
- R8: An untruncated packet closed by an error end delivers its final beat with outEnd=1 and outErr=1, and eepPulse fires once. A truncated packet gives no eepPulse.
- R9: A packet that ends inside the stripped header produces a single marker beat (outNoData=1, outEnd=1), with outErr copied from the input end type.
- R10: After reset, outValid, truncPulse and eepPulse are 0. An output beat stays stable while outValid is high and outReady is low.
- R11: truncPulse and eepPulse are high in the first cycle that the corresponding end beat appears on the output, and never together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input beat valid |
| inReady | output | 1 | Input beat accepted when high with inValid |
| inData | input | DATA_W | Input byte |
| inEnd | input | 1 | Beat is the last of its packet |
| inErr | input | 1 | With inEnd: packet closed by an error end |
| cfgStripAddr | input | 1 | Remove the first byte |
| cfgStripPid | input | 1 | Remove the first and second bytes |
| cfgUseOwnAddr | input | 1 | Match against the channel's own address |
| cfgOwnAddr | input | DATA_W | Channel's own node address |
| cfgNodeAddr | input | DATA_W | Shared node address |
| cfgNoSpill | input | 1 | Stall instead of discarding without a descriptor |
| cfgMaxLen | input | LEN_W | Maximum delivered bytes per packet |
| descAvail | input | 1 | A receive descriptor is ready |
| outValid | output | 1 | Output beat valid |
| outReady | input | 1 | Downstream accepts the output beat |
| outData | output | DATA_W | Output byte (zero on marker beats) |
| outEnd | output | 1 | Output beat closes the packet |
| outErr | output | 1 | Closing beat marks an error end |
| outNoData | output | 1 | Marker beat with no byte |
| truncPulse | output | 1 | Packet was truncated |
| eepPulse | output | 1 | Packet closed by an error end |

## Verification
The checker watches these on every cycle: that a stalled output beat holds stable, that marker beats always close a packet, and that each status pulse coincides with the end beat it describes. It also checks that the two pulses never overlap, that the input is stalled while no-spill waits for a descriptor, and that the discard state always accepts input. Only the bench's packet scenarios can show the byte content of the trimmed stream, which bytes are stripped under each control combination, the address and descriptor discards, and the exact truncation boundary. The bench checks these by comparing every delivered beat and every pulse count against a packet model, under random backpressure.

// File: rtl/rx_hdr_strip_pkg.sv
package rx_hdr_strip_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,   // waiting for the first byte of a packet
    ST_BODY = 2'd1,   // packet admitted, bytes flowing
    ST_DROP = 2'd2    // discarding up to the end marker
  } stripState_e;

  // strobes from control to datapath, valid for one accepted beat
  typedef struct packed {
    logic load;        // write the output register
    logic marker;      // output beat carries no byte
    logic isEnd;       // output beat closes the packet
    logic isErr;       // closing beat is an error end
    logic lenClr;      // clear delivered-byte counter
    logic lenInc;      // count one delivered byte
    logic pulseTrunc;  // raise truncation status
    logic pulseEep;    // raise error-end status
  } dpCtrl_t;

endpackage

// File: rtl/rx_hdr_strip_ctrl.sv
module rx_hdr_strip_ctrl
  import rx_hdr_strip_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inEnd,
  input  logic        inErr,
  input  logic        cfgStripAddr,
  input  logic        cfgStripPid,
  input  logic        cfgNoSpill,
  input  logic        descAvail,
  input  logic        addrMatch,
  input  logic        lenAtMax,
  input  logic        outSpace,
  output logic        inReady,
  output dpCtrl_t     dpCtrl,
  output stripState_e curState
);

  localparam int IDX_W = 2;
  localparam logic [IDX_W-1:0] IDX_SAT = 2'd2;

  stripState_e state, nextState;
  logic [IDX_W-1:0] byteIdx, nextIdx;
  logic stallHold;
  logic stripThis;
  logic accept;

  assign curState = state;

  // header bytes to remove at the current position
  always_comb begin
    stripThis = 1'b0;
    if (byteIdx == 2'd0) stripThis = cfgStripAddr | cfgStripPid;
    else if (byteIdx == 2'd1) stripThis = cfgStripPid;
  end

  assign stallHold = (state == ST_IDLE) && !descAvail && cfgNoSpill;

  always_comb begin
    dpCtrl    = '0;
    nextState = state;
    nextIdx   = byteIdx;
    inReady   = 1'b0;
    accept    = 1'b0;
    case (state)
      ST_DROP: begin
        inReady = 1'b1;
        accept  = inValid;
        if (accept && inEnd) begin
          nextState     = ST_IDLE;
          dpCtrl.lenClr = 1'b1;
        end
      end
      default: begin
        inReady = outSpace && !stallHold;
        accept  = inValid && inReady;
        if (accept) begin
          if (state == ST_IDLE && (!descAvail || !addrMatch)) begin
            // packet refused at its first byte
            if (!inEnd) nextState = ST_DROP;
          end else if (stripThis) begin
            if (inEnd) begin
              dpCtrl.load     = 1'b1;
              dpCtrl.marker   = 1'b1;
              dpCtrl.isEnd    = 1'b1;
              dpCtrl.isErr    = inErr;
              dpCtrl.pulseEep = inErr;
              nextState       = ST_IDLE;
            end else begin
              nextState = ST_BODY;
              nextIdx   = (byteIdx == IDX_SAT) ? IDX_SAT : byteIdx + 1'b1;
            end
          end else if (lenAtMax) begin
            // byte would exceed the limit: close with a plain end marker
            dpCtrl.load       = 1'b1;
            dpCtrl.marker     = 1'b1;
            dpCtrl.isEnd      = 1'b1;
            dpCtrl.pulseTrunc = 1'b1;
            nextState         = inEnd ? ST_IDLE : ST_DROP;
          end else begin
            dpCtrl.load     = 1'b1;
            dpCtrl.isEnd    = inEnd;
            dpCtrl.isErr    = inEnd && inErr;
            dpCtrl.pulseEep = inEnd && inErr;
            dpCtrl.lenInc   = 1'b1;
            nextState       = inEnd ? ST_IDLE : ST_BODY;
            nextIdx         = (byteIdx == IDX_SAT) ? IDX_SAT : byteIdx + 1'b1;
          end
          if (inEnd) dpCtrl.lenClr = 1'b1;
        end
      end
    endcase
    if (nextState != ST_BODY) nextIdx = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      byteIdx <= '0;
    end else begin
      state   <= nextState;
      byteIdx <= nextIdx;
    end
  end

endmodule

// File: rtl/rx_hdr_strip_dp.sv
module rx_hdr_strip_dp
  import rx_hdr_strip_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  logic              cfgUseOwnAddr,
  input  logic [DATA_W-1:0] cfgOwnAddr,
  input  logic [DATA_W-1:0] cfgNodeAddr,
  input  logic [LEN_W-1:0]  cfgMaxLen,
  input  dpCtrl_t           dpCtrl,
  input  logic              outReady,
  output logic              addrMatch,
  output logic              lenAtMax,
  output logic              outSpace,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outEnd,
  output logic              outErr,
  output logic              outNoData,
  output logic              truncPulse,
  output logic              eepPulse
);

  logic [DATA_W-1:0] selAddr;
  logic [LEN_W-1:0]  lenCnt;

  assign selAddr   = cfgUseOwnAddr ? cfgOwnAddr : cfgNodeAddr;
  assign addrMatch = (inData == selAddr);
  assign lenAtMax  = (lenCnt == cfgMaxLen);
  assign outSpace  = !outValid || outReady;

  // delivered-byte counter of the current packet
  always_ff @(posedge clk) begin
    if (!rstN)              lenCnt <= '0;
    else if (dpCtrl.lenClr) lenCnt <= '0;
    else if (dpCtrl.lenInc) lenCnt <= lenCnt + 1'b1;
  end

  // single output register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outData   <= '0;
      outEnd    <= 1'b0;
      outErr    <= 1'b0;
      outNoData <= 1'b0;
    end else if (dpCtrl.load) begin
      outValid  <= 1'b1;
      outData   <= dpCtrl.marker ? '0 : inData;
      outEnd    <= dpCtrl.isEnd;
      outErr    <= dpCtrl.isErr;
      outNoData <= dpCtrl.marker;
    end else if (outReady) begin
      outValid  <= 1'b0;
    end
  end

  // status pulses aligned with the end beat entering the output register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      truncPulse <= 1'b0;
      eepPulse   <= 1'b0;
    end else begin
      truncPulse <= dpCtrl.pulseTrunc;
      eepPulse   <= dpCtrl.pulseEep;
    end
  end

endmodule

// File: rtl/rx_hdr_strip.sv
module rx_hdr_strip
  import rx_hdr_strip_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  input  logic              inEnd,
  input  logic              inErr,
  input  logic              cfgStripAddr,
  input  logic              cfgStripPid,
  input  logic              cfgUseOwnAddr,
  input  logic [DATA_W-1:0] cfgOwnAddr,
  input  logic [DATA_W-1:0] cfgNodeAddr,
  input  logic              cfgNoSpill,
  input  logic [LEN_W-1:0]  cfgMaxLen,
  input  logic              descAvail,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData,
  output logic              outEnd,
  output logic              outErr,
  output logic              outNoData,
  output logic              truncPulse,
  output logic              eepPulse
);

  dpCtrl_t     dpCtrl;
  stripState_e curState;
  logic        addrMatch;
  logic        lenAtMax;
  logic        outSpace;

  rx_hdr_strip_ctrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .inValid      (inValid),
    .inEnd        (inEnd),
    .inErr        (inErr),
    .cfgStripAddr (cfgStripAddr),
    .cfgStripPid  (cfgStripPid),
    .cfgNoSpill   (cfgNoSpill),
    .descAvail    (descAvail),
    .addrMatch    (addrMatch),
    .lenAtMax     (lenAtMax),
    .outSpace     (outSpace),
    .inReady      (inReady),
    .dpCtrl       (dpCtrl),
    .curState     (curState)
  );

  rx_hdr_strip_dp #(.DATA_W(DATA_W), .LEN_W(LEN_W)) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .inData        (inData),
    .cfgUseOwnAddr (cfgUseOwnAddr),
    .cfgOwnAddr    (cfgOwnAddr),
    .cfgNodeAddr   (cfgNodeAddr),
    .cfgMaxLen     (cfgMaxLen),
    .dpCtrl        (dpCtrl),
    .outReady      (outReady),
    .addrMatch     (addrMatch),
    .lenAtMax      (lenAtMax),
    .outSpace      (outSpace),
    .outValid      (outValid),
    .outData       (outData),
    .outEnd        (outEnd),
    .outErr        (outErr),
    .outNoData     (outNoData),
    .truncPulse    (truncPulse),
    .eepPulse      (eepPulse)
  );

endmodule

// File: rtl/rx_hdr_strip_chk.sv
module rx_hdr_strip_chk
  import rx_hdr_strip_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic              cfgNoSpill,
  input logic              descAvail,
  input logic              outValid,
  input logic              outReady,
  input logic [DATA_W-1:0] outData,
  input logic              outEnd,
  input logic              outErr,
  input logic              outNoData,
  input logic              truncPulse,
  input logic              eepPulse,
  input stripState_e       curState
);

  assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outEnd)
                              && $stable(outErr) && $stable(outNoData));

  // marker beats only ever close a packet (R7, R9)
  assert_marker_closes_R9: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outNoData |-> outEnd);

  assert_trunc_marker_R7: assert property (@(posedge clk) disable iff (!rstN)
    truncPulse |-> outValid && outNoData && outEnd && !outErr);

  assert_eep_end_R8: assert property (@(posedge clk) disable iff (!rstN)
    eepPulse |-> outValid && outEnd && outErr);

  assert_pulse_excl_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({truncPulse, eepPulse}));

  assert_nospill_stall_R6: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_IDLE) && inValid && cfgNoSpill && !descAvail |-> !inReady);

  // discard state never back-pressures the link (R4, R5, R7)
  assert_drop_ready_R5: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_DROP) |-> inReady);

endmodule

bind rx_hdr_strip rx_hdr_strip_chk #(.DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .inReady    (inReady),
  .cfgNoSpill (cfgNoSpill),
  .descAvail  (descAvail),
  .outValid   (outValid),
  .outReady   (outReady),
  .outData    (outData),
  .outEnd     (outEnd),
  .outErr     (outErr),
  .outNoData  (outNoData),
  .truncPulse (truncPulse),
  .eepPulse   (eepPulse),
  .curState   (curState)
);

// File: tb/rx_hdr_strip_tb_top.sv
module rx_hdr_strip_tb_top;

  localparam int DW = 8;
  localparam int LW = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic          inValid = 1'b0, inEnd = 1'b0, inErr = 1'b0;
  logic [DW-1:0] inData = '0;
  logic          inReady;
  logic          cfgStripAddr = 0, cfgStripPid = 0, cfgUseOwnAddr = 0, cfgNoSpill = 0;
  logic [DW-1:0] cfgOwnAddr = 8'h33, cfgNodeAddr = 8'h44;
  logic [LW-1:0] cfgMaxLen = 12'd4095;
  logic          descAvail = 1'b1;
  logic          outReady = 1'b1;
  logic          outValid, outEnd, outErr, outNoData, truncPulse, eepPulse;
  logic [DW-1:0] outData;

  int checks = 0, fails = 0;
  bit forceReady = 1'b1;
  logic [10:0] gotQ[$];
  logic [10:0] expQ[$];
  int truncCnt = 0, eepCnt = 0, expTrunc = 0, expEep = 0;
  logic [7:0] pktB[64];
  int pktN = 0;
  bit pktErr = 1'b0;
  int unsigned seedInit;

  rx_hdr_strip #(.DATA_W(DW), .LEN_W(LW)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inData(inData),
    .inEnd(inEnd), .inErr(inErr), .cfgStripAddr(cfgStripAddr), .cfgStripPid(cfgStripPid),
    .cfgUseOwnAddr(cfgUseOwnAddr), .cfgOwnAddr(cfgOwnAddr), .cfgNodeAddr(cfgNodeAddr),
    .cfgNoSpill(cfgNoSpill), .cfgMaxLen(cfgMaxLen), .descAvail(descAvail),
    .outValid(outValid), .outReady(outReady), .outData(outData), .outEnd(outEnd),
    .outErr(outErr), .outNoData(outNoData), .truncPulse(truncPulse), .eepPulse(eepPulse)
  );

  always @(posedge clk) begin
    #1 outReady = forceReady ? 1'b1 : ($urandom % 4 != 0);
  end

  // monitor: mid-cycle values decide the handshake at the next edge
  always @(negedge clk) begin
    if (rstN) begin
      if (outValid && outReady) gotQ.push_back({outNoData, outEnd, outErr, outData});
      if (truncPulse) truncCnt++;
      if (eepPulse) eepCnt++;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // packet model built from the requirements
  task automatic buildExpected();
    int len = 0;
    logic [7:0] addr;
    expQ.delete();
    expTrunc = 0;
    expEep = 0;
    addr = cfgUseOwnAddr ? cfgOwnAddr : cfgNodeAddr;
    if (!descAvail || pktB[0] != addr) return;
    for (int i = 0; i < pktN; i++) begin
      bit last = (i == pktN - 1);
      bit strip = (i == 0 && (cfgStripAddr || cfgStripPid)) || (i == 1 && cfgStripPid);
      if (strip) begin
        if (last) begin
          expQ.push_back({1'b1, 1'b1, pktErr, 8'h00});
          if (pktErr) expEep++;
        end
        continue;
      end
      if (len == int'(cfgMaxLen)) begin
        expQ.push_back({1'b1, 1'b1, 1'b0, 8'h00});
        expTrunc++;
        break;
      end
      expQ.push_back({1'b0, last, last && pktErr, pktB[i]});
      len++;
      if (last && pktErr) expEep++;
    end
  endtask

  task automatic makePkt(int n, bit err, logic [7:0] first);
    pktN = n;
    pktErr = err;
    pktB[0] = first;
    for (int i = 1; i < n; i++) pktB[i] = 8'($urandom);
  endtask

  task automatic sendPacket();
    for (int i = 0; i < pktN; i++) begin
      if ($urandom % 4 == 0) begin
        inValid = 1'b0;
        @(posedge clk); #1;
      end
      inValid = 1'b1;
      inData = pktB[i];
      inEnd = (i == pktN - 1);
      inErr = inEnd && pktErr;
      do @(negedge clk); while (!inReady);
      @(posedge clk); #1;
    end
    inValid = 1'b0;
    inEnd = 1'b0;
    inErr = 1'b0;
  endtask

  task automatic comparePacket(string req);
    forceReady = 1'b1;
    repeat (6) @(posedge clk);
    #1;
    check(gotQ.size() == expQ.size(), req, "beat count", gotQ.size(), expQ.size());
    for (int i = 0; i < gotQ.size() && i < expQ.size(); i++)
      check(gotQ[i] == expQ[i], req, $sformatf("beat %0d {noData,end,err,data}", i),
            int'(gotQ[i]), int'(expQ[i]));
    check(truncCnt == expTrunc, req, "truncPulse count", truncCnt, expTrunc);
    check(eepCnt == expEep, req, "eepPulse count", eepCnt, expEep);
  endtask

  task automatic runPacket(string req);
    gotQ.delete();
    truncCnt = 0;
    eepCnt = 0;
    buildExpected();
    forceReady = 1'b0;
    sendPacket();
    comparePacket(req);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    report();
    $finish;
  end

  initial begin
    seedInit = $urandom(32'h5EED_2024);
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(outValid == 1'b0, "R10", "outValid after reset", outValid, 0);
    check(truncPulse == 1'b0 && eepPulse == 1'b0, "R10", "pulses after reset",
          {truncPulse, eepPulse}, 0);
    @(posedge clk); #1;

    // R3 no stripping
    makePkt(5, 0, 8'h44); runPacket("R3");
    // R1 strip address
    cfgStripAddr = 1; makePkt(6, 0, 8'h44); runPacket("R1");
    // R2 strip pid alone, then both controls
    cfgStripAddr = 0; cfgStripPid = 1; makePkt(6, 0, 8'h44); runPacket("R2");
    cfgStripAddr = 1; makePkt(3, 0, 8'h44); runPacket("R2");
    // R9 packets ending inside the header
    makePkt(2, 1, 8'h44); runPacket("R9");
    cfgStripPid = 0; makePkt(1, 0, 8'h44); runPacket("R9");
    cfgStripAddr = 0;

    // R4 address selection
    cfgUseOwnAddr = 1; makePkt(4, 1, 8'h44); runPacket("R4");
    makePkt(4, 0, 8'h33); runPacket("R4");
    cfgUseOwnAddr = 0; makePkt(4, 0, 8'h33); runPacket("R4");
    makePkt(4, 0, 8'h44); runPacket("R4");

    // R5 discard without a descriptor, then recovery
    descAvail = 0; makePkt(5, 1, 8'h44); runPacket("R5");
    descAvail = 1; makePkt(3, 0, 8'h44); runPacket("R5");

    // R6 stall with no-spill
    cfgNoSpill = 1;
    makePkt(4, 0, 8'h44);
    gotQ.delete(); truncCnt = 0; eepCnt = 0;
    buildExpected();
    descAvail = 0;
    forceReady = 1'b0;
    fork
      sendPacket();
      begin
        repeat (8) @(negedge clk);
        check(inReady == 1'b0, "R6", "inReady while waiting", inReady, 0);
        check(gotQ.size() == 0, "R6", "beats while waiting", gotQ.size(), 0);
        @(posedge clk); #1 descAvail = 1;
      end
    join
    comparePacket("R6");
    cfgNoSpill = 0;

    // R7 length limit after stripping
    cfgMaxLen = 4; cfgStripAddr = 1;
    makePkt(9, 0, 8'h44); runPacket("R7");
    makePkt(5, 0, 8'h44); runPacket("R7");
    makePkt(6, 1, 8'h44); runPacket("R7");
    cfgMaxLen = 0; makePkt(3, 0, 8'h44); runPacket("R7");
    cfgMaxLen = 4095; cfgStripAddr = 0;

    // R8 error end
    makePkt(4, 1, 8'h44); runPacket("R8");

    // R10/R11 random mix under backpressure
    for (int k = 0; k < 60; k++) begin
      cfgStripAddr = $urandom % 2;
      cfgStripPid = ($urandom % 3 == 0);
      cfgUseOwnAddr = $urandom % 2;
      cfgMaxLen = LW'(1 + $urandom % 12);
      descAvail = ($urandom % 8 != 0);
      makePkt(1 + $urandom % 16, $urandom % 3 == 0,
              ($urandom % 4 == 0) ? 8'h55 : (cfgUseOwnAddr ? cfgOwnAddr : cfgNodeAddr));
      runPacket("R11");
    end
    descAvail = 1;

    report();
    $finish;
  end

endmodule